// File: doc/BRIEF.md
# Address-Space-Tagged Translation Buffer

This block is a fully associative cache of page translations. Each slot keeps a valid flag, the virtual page it translates, the physical page it maps to, the address-space number (ASN) of the process that owns it, a global flag, four read-enable and four write-enable permission bits, and two fault-on-access flags. A lookup takes a virtual page number and the current ASN and answers in the same cycle from the stored state. A slot answers a lookup when it is valid, its tag equals the page number, and either its global flag is set or its ASN equals the one presented.

New translations go into the slot named by a round-robin replacement pointer. Any mapping already in that slot is dropped, and the pointer then moves on. Three invalidation commands are provided: clear every slot, clear only the slots that are not global, and clear the slots that would answer a given page and ASN. A read port always shows the slot under the pointer. A separate advance input steps the pointer without writing, so a walker or a maintenance routine can visit every slot in turn.

Top module: `asn_tlb`

## Requirements
- R1: While rst_n is low at a clock edge, every slot becomes invalid and the pointer goes to 0. After reset, no lookup hits and rd_valid is 0.
- R2: lk_hit is 1 only when some slot is valid, its tag equals lk_vpn, and its global flag is 1 or its stored ASN equals lk_asn. On a miss, lk_ppn, lk_rd_en, lk_wr_en, lk_fon_rd and lk_fon_wr are all 0.
- R3: When more than one slot answers a lookup, lk_idx and the data outputs come from the lowest-numbered answering slot.
- R4: An accepted insert writes all of its fields into the slot at the pointer and marks that slot valid. The pointer then moves to the next slot, wrapping from DEPTH-1 to 0.
- R5: An insert into a slot that is already valid replaces the old mapping, so the old page stops hitting unless another slot holds it.
- R6: flush_all invalidates every slot and sets the pointer to 0.
- R7: flush_proc invalidates every slot whose global flag is 0 and leaves global slots valid and unchanged.
- R8: flush_addr invalidates every slot that a lookup with fl_vpn and fl_asn would hit, including global slots. All other slots stay as they are.
- R9: The rd_* outputs show the slot at rd_ptr. idx_adv moves the pointer by one slot (with wrap). When neither idx_adv nor an accepted insert is present, the pointer holds. An insert and idx_adv in the same cycle move it by one slot only.
- R10: The commands have a fixed precedence: flush_all, then flush_proc, then flush_addr, then insert. A command that is outranked in the same cycle has no effect. idx_adv still steps the pointer unless flush_all is present.
- R11: Lookup outputs are combinational from the stored state. A change made by a command at a clock edge is seen by lookups from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_vpn | input | VPN_W | Lookup virtual page number |
| lk_asn | input | ASN_W | Current address-space number |
| lk_hit | output | 1 | Lookup found a slot |
| lk_idx | output | PTR_W | Slot that answered (0 on miss) |
| lk_ppn | output | PPN_W | Physical page of answering slot |
| lk_rd_en | output | PERM_W | Read-enable bits per mode |
| lk_wr_en | output | PERM_W | Write-enable bits per mode |
| lk_fon_rd | output | 1 | Fault-on-read flag |
| lk_fon_wr | output | 1 | Fault-on-write flag |
| ins_en | input | 1 | Insert a translation at the pointer |
| ins_vpn | input | VPN_W | Page to insert |
| ins_ppn | input | PPN_W | Physical page to insert |
| ins_asn | input | ASN_W | Owner ASN |
| ins_global | input | 1 | Global flag |
| ins_rd_en | input | PERM_W | Read-enable bits |
| ins_wr_en | input | PERM_W | Write-enable bits |
| ins_fon_rd | input | 1 | Fault-on-read flag |
| ins_fon_wr | input | 1 | Fault-on-write flag |
| flush_all | input | 1 | Invalidate all slots, pointer to 0 |
| flush_proc | input | 1 | Invalidate non-global slots |
| flush_addr | input | 1 | Invalidate slots matching fl_vpn/fl_asn |
| fl_vpn | input | VPN_W | Page for flush_addr |
| fl_asn | input | ASN_W | ASN for flush_addr |
| idx_adv | input | 1 | Step the pointer |
| rd_ptr | output | PTR_W | Current replacement pointer |
| rd_valid | output | 1 | Valid flag of slot at pointer |
| rd_vpn | output | VPN_W | Tag of slot at pointer |
| rd_asn | output | ASN_W | ASN of slot at pointer |
| rd_global | output | 1 | Global flag of slot at pointer |
| rd_ppn | output | PPN_W | Physical page of slot at pointer |
| rd_rd_en | output | PERM_W | Read-enable bits of slot at pointer |
| rd_wr_en | output | PERM_W | Write-enable bits of slot at pointer |
| rd_fon_rd | output | 1 | Fault-on-read of slot at pointer |
| rd_fon_wr | output | 1 | Fault-on-write of slot at pointer |

## Verification
Lookup and read-port results are due in the same cycle their inputs are applied, with no register on the way. Every command, insert or pointer step shows up one clock edge later. The bench drives inputs on the falling edge and compares every output against its reference model a quarter period later, before the rising edge. It updates the model just after that edge, so a command is never seen by a lookup in its own cycle. Insert streams long enough to wrap the pointer, duplicate tags, ASN mismatches against global slots, and cycles with several commands at once each get their own phase.

// File: rtl/asn_tlb_pkg.sv
// Shared types for the address-space-tagged translation buffer.
// Assumes: at most one table-changing command takes effect per cycle.
package asn_tlb_pkg;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_FLUSH_ALL,
        OP_FLUSH_PROC,
        OP_FLUSH_ADDR,
        OP_INSERT
    } tlb_op_e;

    // Pick the one command that wins this cycle, by fixed precedence.
    function automatic tlb_op_e pick_op(input logic fa, input logic fp,
                                        input logic fd, input logic ins);
        if (fa)       return OP_FLUSH_ALL;
        else if (fp)  return OP_FLUSH_PROC;
        else if (fd)  return OP_FLUSH_ADDR;
        else if (ins) return OP_INSERT;
        else          return OP_NONE;
    endfunction

endpackage

// File: rtl/asn_tlb_match.sv
// Compare one key (page, ASN) against every slot in parallel.
// Assumes: the caller qualifies with the valid vector passed in.
module asn_tlb_match #(
    parameter int DEPTH = 48,
    parameter int VPN_W = 20,
    parameter int ASN_W = 8
) (
    input  logic [DEPTH-1:0]            valid,
    input  logic [DEPTH-1:0]            glob,
    input  logic [DEPTH-1:0][VPN_W-1:0] tags,
    input  logic [DEPTH-1:0][ASN_W-1:0] asns,
    input  logic [VPN_W-1:0]            key_vpn,
    input  logic [ASN_W-1:0]            key_asn,
    output logic [DEPTH-1:0]            hit_vec
);

    genvar g;
    generate
        for (g = 0; g < DEPTH; g++) begin : g_slot
            // Per-slot hit: valid, tag equal, and global or same owner.
            assign hit_vec[g] = valid[g] && (tags[g] == key_vpn) &&
                                (glob[g] || (asns[g] == key_asn));
        end
    endgenerate

endmodule

// File: rtl/asn_tlb_prio.sv
// Lowest-index-first priority encoder over a request vector.
// Assumes: idx is 0 when no request bit is set.
module asn_tlb_prio #(
    parameter int DEPTH = 48,
    parameter int IDX_W = 6
) (
    input  logic [DEPTH-1:0] req,
    output logic             found,
    output logic [IDX_W-1:0] idx
);

    // Scan from the top so the lowest set bit is written last.
    always_comb begin
        found = |req;
        idx   = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/asn_tlb_rrptr.sv
// Round-robin replacement pointer with clear and single-step.
// Assumes: clear outranks step.
module asn_tlb_rrptr #(
    parameter int DEPTH = 48,
    parameter int PTR_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    output logic [PTR_W-1:0] ptr
);

    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    // Hold, clear, or advance with wrap at the last slot.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) ptr <= '0;
        else if (step)       ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
    end

endmodule

// File: rtl/asn_tlb.sv
// Fully associative translation buffer tagged by address-space number.
// Lookup is combinational; inserts go to a round-robin pointer; three
// invalidation commands. Assumes DEPTH >= 2; one command wins per cycle.
module asn_tlb
    import asn_tlb_pkg::*;
#(
    parameter int DEPTH  = 48,
    parameter int VPN_W  = 20,
    parameter int PPN_W  = 16,
    parameter int ASN_W  = 8,
    parameter int PERM_W = 4,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [ASN_W-1:0]  lk_asn,
    output logic              lk_hit,
    output logic [PTR_W-1:0]  lk_idx,
    output logic [PPN_W-1:0]  lk_ppn,
    output logic [PERM_W-1:0] lk_rd_en,
    output logic [PERM_W-1:0] lk_wr_en,
    output logic              lk_fon_rd,
    output logic              lk_fon_wr,
    input  logic              ins_en,
    input  logic [VPN_W-1:0]  ins_vpn,
    input  logic [PPN_W-1:0]  ins_ppn,
    input  logic [ASN_W-1:0]  ins_asn,
    input  logic              ins_global,
    input  logic [PERM_W-1:0] ins_rd_en,
    input  logic [PERM_W-1:0] ins_wr_en,
    input  logic              ins_fon_rd,
    input  logic              ins_fon_wr,
    input  logic              flush_all,
    input  logic              flush_proc,
    input  logic              flush_addr,
    input  logic [VPN_W-1:0]  fl_vpn,
    input  logic [ASN_W-1:0]  fl_asn,
    input  logic              idx_adv,
    output logic [PTR_W-1:0]  rd_ptr,
    output logic              rd_valid,
    output logic [VPN_W-1:0]  rd_vpn,
    output logic [ASN_W-1:0]  rd_asn,
    output logic              rd_global,
    output logic [PPN_W-1:0]  rd_ppn,
    output logic [PERM_W-1:0] rd_rd_en,
    output logic [PERM_W-1:0] rd_wr_en,
    output logic              rd_fon_rd,
    output logic              rd_fon_wr
);

    localparam int DATA_W = PPN_W + 2 * PERM_W + 2;

    logic [DEPTH-1:0]             valid_q;
    logic [DEPTH-1:0]             glob_q;
    logic [DEPTH-1:0][VPN_W-1:0]  tag_q;
    logic [DEPTH-1:0][ASN_W-1:0]  asn_q;
    logic [DEPTH-1:0][DATA_W-1:0] data_q;

    logic [DEPTH-1:0]  lk_match;
    logic [DEPTH-1:0]  fl_match;
    logic              lk_found;
    logic [PTR_W-1:0]  lk_sel;
    logic [DATA_W-1:0] lk_data;
    logic [DATA_W-1:0] rd_data;
    logic [DATA_W-1:0] ins_data;
    logic [PTR_W-1:0]  ptr;
    tlb_op_e           op;

    // Decode this cycle's winning command.
    assign op       = pick_op(flush_all, flush_proc, flush_addr, ins_en);
    assign ins_data = {ins_ppn, ins_rd_en, ins_wr_en, ins_fon_rd, ins_fon_wr};

    asn_tlb_match #(.DEPTH(DEPTH), .VPN_W(VPN_W), .ASN_W(ASN_W)) u_lk_match (
        .valid(valid_q), .glob(glob_q), .tags(tag_q), .asns(asn_q),
        .key_vpn(lk_vpn), .key_asn(lk_asn), .hit_vec(lk_match)
    );

    asn_tlb_match #(.DEPTH(DEPTH), .VPN_W(VPN_W), .ASN_W(ASN_W)) u_fl_match (
        .valid(valid_q), .glob(glob_q), .tags(tag_q), .asns(asn_q),
        .key_vpn(fl_vpn), .key_asn(fl_asn), .hit_vec(fl_match)
    );

    asn_tlb_prio #(.DEPTH(DEPTH), .IDX_W(PTR_W)) u_prio (
        .req(lk_match), .found(lk_found), .idx(lk_sel)
    );

    asn_tlb_rrptr #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_ptr (
        .clk(clk), .rst_n(rst_n),
        .clear(op == OP_FLUSH_ALL),
        .step((op == OP_INSERT) || idx_adv),
        .ptr(ptr)
    );

    // Valid flags: reset, the three flushes, and set on insert.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else begin
            case (op)
                OP_FLUSH_ALL:  valid_q <= '0;
                OP_FLUSH_PROC: valid_q <= valid_q & glob_q;
                OP_FLUSH_ADDR: valid_q <= valid_q & ~fl_match;
                OP_INSERT:     valid_q[ptr] <= 1'b1;
                default:       valid_q <= valid_q;
            endcase
        end
    end

    // Slot contents: overwritten only by an accepted insert.
    always_ff @(posedge clk) begin
        if (rst_n && (op == OP_INSERT)) begin
            tag_q[ptr]  <= ins_vpn;
            asn_q[ptr]  <= ins_asn;
            glob_q[ptr] <= ins_global;
            data_q[ptr] <= ins_data;
        end
    end

    // Lookup result: data of the winning slot, zero on a miss.
    always_comb begin
        lk_hit  = lk_found;
        lk_idx  = lk_sel;
        lk_data = lk_found ? data_q[lk_sel] : '0;
        {lk_ppn, lk_rd_en, lk_wr_en, lk_fon_rd, lk_fon_wr} = lk_data;
    end

    // Read port: the slot under the pointer.
    always_comb begin
        rd_ptr    = ptr;
        rd_valid  = valid_q[ptr];
        rd_vpn    = tag_q[ptr];
        rd_asn    = asn_q[ptr];
        rd_global = glob_q[ptr];
        rd_data   = data_q[ptr];
        {rd_ppn, rd_rd_en, rd_wr_en, rd_fon_rd, rd_fon_wr} = rd_data;
    end

endmodule

// File: rtl/asn_tlb_chk.sv
// Property checker for asn_tlb, bound into every instance.
// Assumes: sees the top's valid and global vectors through the bind.
module asn_tlb_chk #(
    parameter int DEPTH = 48,
    parameter int PTR_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             flush_all,
    input logic             flush_proc,
    input logic             flush_addr,
    input logic             ins_en,
    input logic             idx_adv,
    input logic [PTR_W-1:0] rd_ptr,
    input logic [DEPTH-1:0] valid_q,
    input logic [DEPTH-1:0] glob_q,
    input logic             lk_hit,
    input logic [PTR_W-1:0] lk_idx
);

    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    logic was_rst;

    // Remember whether the previous edge was a reset edge.
    always_ff @(posedge clk) was_rst <= !rst_n;

    // R1: right after reset the table is empty and the pointer is home.
    assert_reset_empty_R1: assert property (@(posedge clk) disable iff (!rst_n)
        was_rst |-> (valid_q == '0) && (rd_ptr == '0));

    // R2: a reported hit names a valid slot.
    assert_hit_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> valid_q[lk_idx]);

    // R6: flush_all empties the table and homes the pointer.
    assert_flush_all_R6: assert property (@(posedge clk) disable iff (!rst_n)
        flush_all |=> (valid_q == '0) && (rd_ptr == '0));

    // R7: flush_proc keeps exactly the valid global slots.
    assert_flush_proc_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_proc && !flush_all) |=> valid_q == ($past(valid_q) & $past(glob_q)));

    // R4: an accepted insert validates the slot and steps the pointer.
    assert_insert_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_en && !flush_all && !flush_proc && !flush_addr) |=>
        valid_q[$past(rd_ptr)] &&
        (rd_ptr == (($past(rd_ptr) == LAST) ? '0 : $past(rd_ptr) + 1'b1)));

    // R9: with no step request and no flush_all the pointer holds.
    assert_ptr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!ins_en && !idx_adv && !flush_all) |=> $stable(rd_ptr));

    // R8: flush_addr never makes a slot valid.
    assert_flush_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_addr && !flush_all && !flush_proc) |=>
        (valid_q & ~$past(valid_q)) == '0);

endmodule

bind asn_tlb asn_tlb_chk #(.DEPTH(DEPTH), .PTR_W(PTR_W)) u_asn_tlb_chk (
    .clk(clk), .rst_n(rst_n), .flush_all(flush_all), .flush_proc(flush_proc),
    .flush_addr(flush_addr), .ins_en(ins_en), .idx_adv(idx_adv),
    .rd_ptr(rd_ptr), .valid_q(valid_q), .glob_q(glob_q),
    .lk_hit(lk_hit), .lk_idx(lk_idx)
);

// File: tb/asn_tlb_bench.sv
// Bench: behavioural reference model compared on every clock cycle.
module asn_tlb_bench;

    localparam int D  = 8;
    localparam int VW = 20;
    localparam int PW = 16;
    localparam int AW = 8;
    localparam int QW = 4;
    localparam int IW = $clog2(D);

    logic clk = 0;
    logic rst_n = 0;
    logic [VW-1:0] lk_vpn = '0, ins_vpn = '0, fl_vpn = '0;
    logic [AW-1:0] lk_asn = '0, ins_asn = '0, fl_asn = '0;
    logic [PW-1:0] ins_ppn = '0;
    logic [QW-1:0] ins_rd_en = '0, ins_wr_en = '0;
    logic ins_en = 0, ins_global = 0, ins_fon_rd = 0, ins_fon_wr = 0;
    logic flush_all = 0, flush_proc = 0, flush_addr = 0, idx_adv = 0;

    logic          lk_hit, lk_fon_rd, lk_fon_wr;
    logic [IW-1:0] lk_idx, rd_ptr;
    logic [PW-1:0] lk_ppn, rd_ppn;
    logic [QW-1:0] lk_rd_en, lk_wr_en, rd_rd_en, rd_wr_en;
    logic          rd_valid, rd_global, rd_fon_rd, rd_fon_wr;
    logic [VW-1:0] rd_vpn;
    logic [AW-1:0] rd_asn;

    asn_tlb #(.DEPTH(D), .VPN_W(VW), .PPN_W(PW), .ASN_W(AW), .PERM_W(QW)) u_asn_tlb (
        .clk(clk), .rst_n(rst_n), .lk_vpn(lk_vpn), .lk_asn(lk_asn),
        .lk_hit(lk_hit), .lk_idx(lk_idx), .lk_ppn(lk_ppn), .lk_rd_en(lk_rd_en),
        .lk_wr_en(lk_wr_en), .lk_fon_rd(lk_fon_rd), .lk_fon_wr(lk_fon_wr),
        .ins_en(ins_en), .ins_vpn(ins_vpn), .ins_ppn(ins_ppn), .ins_asn(ins_asn),
        .ins_global(ins_global), .ins_rd_en(ins_rd_en), .ins_wr_en(ins_wr_en),
        .ins_fon_rd(ins_fon_rd), .ins_fon_wr(ins_fon_wr),
        .flush_all(flush_all), .flush_proc(flush_proc), .flush_addr(flush_addr),
        .fl_vpn(fl_vpn), .fl_asn(fl_asn), .idx_adv(idx_adv),
        .rd_ptr(rd_ptr), .rd_valid(rd_valid), .rd_vpn(rd_vpn), .rd_asn(rd_asn),
        .rd_global(rd_global), .rd_ppn(rd_ppn), .rd_rd_en(rd_rd_en),
        .rd_wr_en(rd_wr_en), .rd_fon_rd(rd_fon_rd), .rd_fon_wr(rd_fon_wr)
    );

    always #10 clk = ~clk;

    int nchecks = 0;
    int nerrs = 0;
    string req = "R1";

    // Reference state
    bit          m_v[D];
    bit          m_g[D];
    int unsigned m_tag[D], m_asn[D], m_ppn[D], m_re[D], m_we[D], m_fr[D], m_fw[D];
    int          m_ptr = 0;

    task automatic check(input string what, input longint act, input longint exp);
        nchecks++;
        if (act !== exp) begin
            nerrs++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic bit m_match(int i, int unsigned v, int unsigned a);
        return m_v[i] && m_tag[i] == v && (m_g[i] || m_asn[i] == a);
    endfunction

    // Compare all outputs against the model before the edge, then update.
    task automatic cyc();
        int ei;
        bit eh;
        #5;
        eh = 0; ei = 0;
        for (int i = 0; i < D; i++)
            if (!eh && m_match(i, lk_vpn, lk_asn)) begin eh = 1; ei = i; end
        check("lk_hit", lk_hit, eh);
        check("lk_idx", lk_idx, eh ? ei : 0);
        check("lk_ppn", lk_ppn, eh ? m_ppn[ei] : 0);
        check("lk_rd_en", lk_rd_en, eh ? m_re[ei] : 0);
        check("lk_wr_en", lk_wr_en, eh ? m_we[ei] : 0);
        check("lk_fon", {lk_fon_rd, lk_fon_wr}, eh ? {m_fr[ei][0], m_fw[ei][0]} : 0);
        check("rd_ptr", rd_ptr, m_ptr);
        check("rd_valid", rd_valid, m_v[m_ptr]);
        if (m_v[m_ptr]) begin
            check("rd_vpn", rd_vpn, m_tag[m_ptr]);
            check("rd_asn", rd_asn, m_asn[m_ptr]);
            check("rd_global", rd_global, m_g[m_ptr]);
            check("rd_ppn", rd_ppn, m_ppn[m_ptr]);
            check("rd_perm", {rd_rd_en, rd_wr_en}, {m_re[m_ptr][QW-1:0], m_we[m_ptr][QW-1:0]});
            check("rd_fon", {rd_fon_rd, rd_fon_wr}, {m_fr[m_ptr][0], m_fw[m_ptr][0]});
        end
        @(posedge clk);
        #1;
        if (!rst_n || flush_all) begin
            for (int i = 0; i < D; i++) m_v[i] = 0;
            m_ptr = 0;
        end else begin
            if (flush_proc) begin
                for (int i = 0; i < D; i++) if (!m_g[i]) m_v[i] = 0;
            end else if (flush_addr) begin
                for (int i = 0; i < D; i++) if (m_match(i, fl_vpn, fl_asn)) m_v[i] = 0;
            end else if (ins_en) begin
                m_v[m_ptr] = 1; m_tag[m_ptr] = ins_vpn; m_asn[m_ptr] = ins_asn;
                m_g[m_ptr] = ins_global; m_ppn[m_ptr] = ins_ppn;
                m_re[m_ptr] = ins_rd_en; m_we[m_ptr] = ins_wr_en;
                m_fr[m_ptr] = ins_fon_rd; m_fw[m_ptr] = ins_fon_wr;
            end
            if ((ins_en && !flush_proc && !flush_addr) || idx_adv)
                m_ptr = (m_ptr + 1) % D;
        end
        @(negedge clk);
    endtask

    task automatic idle();
        ins_en = 0; flush_all = 0; flush_proc = 0; flush_addr = 0; idx_adv = 0;
    endtask

    task automatic put(input int v, input int a, input bit g, input int p);
        ins_en = 1; ins_vpn = VW'(v); ins_asn = AW'(a); ins_global = g;
        ins_ppn = PW'(p); ins_rd_en = QW'(p); ins_wr_en = QW'(p >> 2);
        ins_fon_rd = p[0]; ins_fon_wr = p[1];
    endtask

    task automatic look(input int v, input int a);
        lk_vpn = VW'(v); lk_asn = AW'(a);
    endtask

    initial begin
        #4_000_000;
        nerrs++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrs);
        $finish;
    end

    initial begin
        @(negedge clk);
        // R1: reset, including a stray insert held during reset.
        req = "R1";
        put(5, 1, 0, 'h11);
        cyc(); cyc();
        rst_n = 1; idle(); look(5, 1);
        cyc();
        check("R1 rd_valid after reset", rd_valid, 0);

        // R4: fill every slot, mixed ASNs and global flags; R11 same-cycle miss.
        req = "R4";
        for (int i = 0; i < D; i++) begin
            put(16 + i, i % 3, (i % 4) == 3, 'h100 + i * 7);
            look(16 + i, i % 3);
            req = "R11"; cyc(); req = "R4";
        end
        idle();
        // R2: hits, ASN mismatch misses, global hits with any ASN.
        req = "R2";
        for (int i = 0; i < D; i++) begin
            look(16 + i, i % 3);        cyc();
            look(16 + i, (i % 3) + 1);  cyc();
            look(16 + i, 9);            cyc();
        end
        look(999, 0); cyc();

        // R5: wrap; overwrite slot 0 with a new page.
        req = "R5";
        put(400, 2, 0, 'hABC); look(16, 0); cyc();
        idle(); cyc();
        look(400, 2); cyc();
        check("R4 wrapped pointer", rd_ptr, 1);

        // R3: duplicate tags, lowest slot wins.
        req = "R3";
        put(500, 4, 0, 'h55); cyc();
        put(500, 4, 1, 'h66); cyc();
        put(500, 7, 1, 'h77); cyc();
        idle(); look(500, 4); cyc();
        look(500, 7); cyc();
        look(500, 3); cyc();

        // R9: read-port walk with idx_adv, and hold without it.
        req = "R9";
        for (int i = 0; i < D + 2; i++) begin idx_adv = 1; cyc(); end
        idx_adv = 0; cyc(); cyc();
        put(600, 1, 0, 'h3); idx_adv = 1; cyc();
        idle(); look(600, 1); cyc();

        // R8: flush by address, including a global slot under another ASN.
        req = "R8";
        flush_addr = 1; fl_vpn = 500; fl_asn = 9; look(500, 7); cyc();
        idle(); cyc(); look(500, 4); cyc();
        flush_addr = 1; fl_vpn = 500; fl_asn = 4; cyc();
        idle(); cyc();
        flush_addr = 1; fl_vpn = 12345; fl_asn = 0; look(400, 2); cyc();
        idle(); cyc();

        // R10: combined commands, lower ones ignored.
        req = "R10";
        put(700, 0, 0, 'h9); flush_addr = 1; fl_vpn = 400; fl_asn = 2; look(700, 0); cyc();
        idle(); cyc();
        put(701, 0, 0, 'h9); flush_proc = 1; idx_adv = 1; look(19, 0); cyc();
        idle(); cyc();
        look(701, 0); cyc();

        // R7: flush processes keeps globals.
        req = "R7";
        for (int i = 0; i < 4; i++) begin put(800 + i, i, i[0], 'h20 + i); cyc(); end
        idle(); flush_proc = 1; cyc();
        idle();
        for (int i = 0; i < 4; i++) begin look(800 + i, 5); cyc(); end

        // R6: flush all, combined with insert and idx_adv.
        req = "R6";
        idx_adv = 1; cyc(); cyc();
        put(900, 1, 1, 'h1); flush_all = 1; idx_adv = 1; look(801, 5); cyc();
        idle(); cyc();
        look(900, 1); cyc();
        check("R6 pointer home", rd_ptr, 0);

        $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrs);
        $finish;
    end

endmodule